// File: doc/BRIEF.md
# Read-After-Write Bypass and Load Interlock Controller

This block is the dependence controller of a five-stage in-order integer pipeline. Each cycle it receives the decoded register fields of the instruction sitting in the decode stage. It keeps its own short shadow of the destination, write-enable, load and store tags for the instructions now in execute and memory. From that shadow it produces three things. The first is a combinational stall that holds the fetch address and the decode register. The second is a bubble into the execute stage. The third is a set of registered operand-select codes for the bypass multiplexers, which are valid in the cycle the consumer occupies execute.

Every dependence is sorted by how far the consumer is from its producer. A load directly ahead of an ALU consumer forces one stall cycle. A producer one slot ahead that is not a load is bypassed from the execute/memory register. A producer two slots ahead, load or not, is bypassed from the memory/writeback register. A producer three slots ahead needs nothing, because the register file writes before it reads within a cycle. Store data that depends on the load directly ahead is not stalled: it is patched in the memory stage from the writeback value.

Top module: `raw_hazard_ctrl`

## Requirements
- R1: When the execute stage holds a load with write enable set and a nonzero destination equal to a used source of the decode instruction, `stall_o` is 1 in that same cycle; a store's second source (its data) never causes this stall.
- R2: A stall lasts exactly one cycle, and after the clock edge that ends it `ex_wr_en_o`, `ex_st_en_o`, `fwd_a_o` and `fwd_b_o` are all 0 (a bubble); otherwise `ex_wr_en_o`/`ex_st_en_o` follow the write/store flags of the instruction that entered execute.
- R3: Select encoding is 2'b00 register file, 2'b01 memory/writeback, 2'b10 execute/memory; after the edge that moves a consumer into execute, an operand whose producer is the non-load instruction one slot ahead reads 2'b10.
- R4: An operand whose producer (load or ALU) is two slots ahead reads 2'b01.
- R5: An operand whose producer is three or more slots ahead reads 2'b00.
- R6: When both older slots write the same register, the nearer one (2'b10) wins.
- R7: Register 0 never causes a stall or a nonzero select, either as source or as destination.
- R8: A source flagged unused, or a producer with write enable clear, causes neither stall nor bypass.
- R9: A store whose data register equals the destination of the load directly ahead is not stalled, and `fwd_st_o` is 1 in the cycle the store is in memory (load in writeback); otherwise it is 0.
- R10: Synchronous reset empties the tracked stages, so all outputs are 0 afterwards and no pre-reset load causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1_i | input | 5 | First source register of decode instruction |
| id_rs2_i | input | 5 | Second source register (store data for stores) |
| id_rd_i | input | 5 | Destination register of decode instruction |
| id_use_rs1_i | input | 1 | First source is read |
| id_use_rs2_i | input | 1 | Second source is read |
| id_wr_i | input | 1 | Instruction writes the register file |
| id_ld_i | input | 1 | Instruction is a load |
| id_st_i | input | 1 | Instruction is a store |
| stall_o | output | 1 | Hold fetch address and decode register, bubble execute |
| fwd_a_o | output | 2 | Bypass select, first ALU operand |
| fwd_b_o | output | 2 | Bypass select, second ALU operand / store data in execute |
| fwd_st_o | output | 1 | Replace store data in memory stage with writeback value |
| ex_wr_en_o | output | 1 | Register write enable of the instruction in execute |
| ex_st_en_o | output | 1 | Memory write enable of the instruction in execute |

## Verification
The assertions assume that the surrounding pipeline obeys `stall_o`: the decode fields seen in the cycle after a stall belong to the same instruction, and every field changes only once per cycle. They also assume that the use flags are honest, so a set flag means the source is really consumed. The stimulus table is written as a cycle-by-cycle trace that repeats a stalled instruction on the next row and drives inputs only between clock edges. This keeps the tracked shadow aligned with the sequence that a real pipeline would present.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int RA_W   = 5;
  localparam int N_OPND = 2;

  typedef logic [RA_W-1:0] reg_idx_t;

  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_WB  = 2'b01,
    BYP_MEM = 2'b10
  } byp_sel_e;

  typedef struct packed {
    reg_idx_t rd;
    reg_idx_t rs2;
    logic     wr;
    logic     ld;
    logic     st;
  } stage_tag_t;
endpackage

// File: rtl/hz_stage_track.sv
module hz_stage_track
  import hz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bubble_i,
  input  stage_tag_t id_tag_i,
  output stage_tag_t ex_tag_o,
  output stage_tag_t mem_tag_o
);
  stage_tag_t ex_q, mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_q  <= '0;
      mem_q <= '0;
    end else begin
      ex_q  <= bubble_i ? '0 : id_tag_i;
      mem_q <= ex_q;
    end
  end

  assign ex_tag_o  = ex_q;
  assign mem_tag_o = mem_q;
endmodule

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect
  import hz_pkg::*;
(
  input  reg_idx_t   rs1_i,
  input  reg_idx_t   rs2_i,
  input  logic       use_rs1_i,
  input  logic       use_rs2_i,
  input  logic       is_store_i,
  input  stage_tag_t ex_tag_i,
  output logic       stall_o
);
  logic load_ahead;
  logic hit1, hit2;

  always_comb begin
    load_ahead = ex_tag_i.ld && ex_tag_i.wr && (ex_tag_i.rd != '0);
    hit1       = use_rs1_i && (rs1_i == ex_tag_i.rd);
    // store data is patched in the memory stage instead of stalling
    hit2       = use_rs2_i && !is_store_i && (rs2_i == ex_tag_i.rd);
    stall_o    = load_ahead && (hit1 || hit2);
  end
endmodule

// File: rtl/hz_bypass_sel.sv
module hz_bypass_sel
  import hz_pkg::*;
#(
  parameter int NOPND = N_OPND
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kill_i,
  input  reg_idx_t   src_i  [NOPND],
  input  logic       used_i [NOPND],
  input  stage_tag_t ex_tag_i,
  input  stage_tag_t mem_tag_i,
  output byp_sel_e   sel_o  [NOPND],
  output logic       st_fwd_o
);
  logic ex_can, mem_can;
  assign ex_can  = ex_tag_i.wr && !ex_tag_i.ld && (ex_tag_i.rd != '0);
  assign mem_can = mem_tag_i.wr && (mem_tag_i.rd != '0);

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    byp_sel_e sel_d, sel_q;

    always_comb begin
      sel_d = BYP_RF;
      if (!kill_i && used_i[g]) begin
        if (ex_can && (ex_tag_i.rd == src_i[g]))
          sel_d = BYP_MEM;
        else if (mem_can && (mem_tag_i.rd == src_i[g]))
          sel_d = BYP_WB;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) sel_q <= BYP_RF;
      else     sel_q <= sel_d;
    end

    assign sel_o[g] = sel_q;

    // R7/R8: a nonzero select needs a used, nonzero source
    assert_src_valid_R7: assert property (@(posedge clk) disable iff (rst)
      (sel_q != BYP_RF) |-> ($past(used_i[g]) && ($past(src_i[g]) != '0)));

    // R3: the near path only ever serves a writing non-load producer
    assert_near_alu_R3: assert property (@(posedge clk) disable iff (rst)
      (sel_q == BYP_MEM) |-> ($past(ex_tag_i.wr) && !$past(ex_tag_i.ld)));
  end

  logic st_fwd_q;
  always_ff @(posedge clk) begin
    if (rst) st_fwd_q <= 1'b0;
    else     st_fwd_q <= ex_tag_i.st && mem_tag_i.ld && mem_can &&
                         (mem_tag_i.rd == ex_tag_i.rs2);
  end
  assign st_fwd_o = st_fwd_q;
endmodule

// File: rtl/raw_hazard_ctrl.sv
module raw_hazard_ctrl
  import hz_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [RA_W-1:0]   id_rs1_i,
  input  logic [RA_W-1:0]   id_rs2_i,
  input  logic [RA_W-1:0]   id_rd_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_wr_i,
  input  logic              id_ld_i,
  input  logic              id_st_i,
  output logic              stall_o,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic              fwd_st_o,
  output logic              ex_wr_en_o,
  output logic              ex_st_en_o
);
  stage_tag_t id_tag, ex_tag, mem_tag;
  logic       stall;
  reg_idx_t   src  [N_OPND];
  logic       used [N_OPND];
  byp_sel_e   sel  [N_OPND];

  always_comb begin
    id_tag.rd  = id_rd_i;
    id_tag.rs2 = id_rs2_i;
    id_tag.wr  = id_wr_i;
    id_tag.ld  = id_ld_i;
    id_tag.st  = id_st_i;
  end

  assign src[0]  = id_rs1_i;
  assign src[1]  = id_rs2_i;
  assign used[0] = id_use_rs1_i;
  assign used[1] = id_use_rs2_i;

  hz_loaduse_detect u_det (
    .rs1_i     (id_rs1_i),
    .rs2_i     (id_rs2_i),
    .use_rs1_i (id_use_rs1_i),
    .use_rs2_i (id_use_rs2_i),
    .is_store_i(id_st_i),
    .ex_tag_i  (ex_tag),
    .stall_o   (stall)
  );

  hz_stage_track u_trk (
    .clk      (clk),
    .rst      (rst),
    .bubble_i (stall),
    .id_tag_i (id_tag),
    .ex_tag_o (ex_tag),
    .mem_tag_o(mem_tag)
  );

  hz_bypass_sel #(.NOPND(N_OPND)) u_byp (
    .clk      (clk),
    .rst      (rst),
    .kill_i   (stall),
    .src_i    (src),
    .used_i   (used),
    .ex_tag_i (ex_tag),
    .mem_tag_i(mem_tag),
    .sel_o    (sel),
    .st_fwd_o (fwd_st_o)
  );

  assign stall_o    = stall;
  assign fwd_a_o    = sel[0];
  assign fwd_b_o    = sel[1];
  assign ex_wr_en_o = ex_tag.wr;
  assign ex_st_en_o = ex_tag.st;

  // R2: never two stall cycles in a row
  assert_single_stall_R2: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> !stall_o);

  // R2: the cycle after a stall carries a bubble in execute
  assert_bubble_R2: assert property (@(posedge clk) disable iff (rst)
    stall_o |=> (!ex_wr_en_o && !ex_st_en_o && fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

  // R9: a store-data patch follows a store that was in execute
  assert_st_patch_R9: assert property (@(posedge clk) disable iff (rst)
    fwd_st_o |-> $past(ex_st_en_o));
endmodule

// File: tb/sim_raw_hazard_ctrl.sv
module sim_raw_hazard_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rs1 = '0, rs2 = '0, rd = '0;
  logic       u1 = 0, u2 = 0, wr = 0, ld = 0, st = 0;
  logic       stall, fs, exwr, exst;
  logic [1:0] fa, fb;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  raw_hazard_ctrl u0 (
    .clk(clk), .rst(rst),
    .id_rs1_i(rs1), .id_rs2_i(rs2), .id_rd_i(rd),
    .id_use_rs1_i(u1), .id_use_rs2_i(u2),
    .id_wr_i(wr), .id_ld_i(ld), .id_st_i(st),
    .stall_o(stall), .fwd_a_o(fa), .fwd_b_o(fb), .fwd_st_o(fs),
    .ex_wr_en_o(exwr), .ex_st_en_o(exst)
  );

  // row: rs1, rs2, rd, {u1,u2,wr,ld,st}, stall, fa, fb, fs, {exwr,exst}
  localparam int NR = 23;
  localparam logic [27:0] ROWS [NR] = '{
    {5'd2, 5'd3, 5'd1, 5'b11100, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd1, 5'd5, 5'd4, 5'b11100, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10},
    {5'd7, 5'd1, 5'd6, 5'b11100, 1'b0, 2'd0, 2'd1, 1'b0, 2'b10},
    {5'd1, 5'd9, 5'd8, 5'b11100, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd8, 5'd0, 5'd10,5'b10110, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10},
    {5'd10,5'd2, 5'd11,5'b11100, 1'b1, 2'd0, 2'd0, 1'b0, 2'b00},
    {5'd10,5'd2, 5'd11,5'b11100, 1'b0, 2'd1, 2'd0, 1'b0, 2'b10},
    {5'd0, 5'd0, 5'd12,5'b10110, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd11,5'd12,5'd0, 5'b11001, 1'b0, 2'd1, 2'd0, 1'b0, 2'b01},
    {5'd0, 5'd0, 5'd0, 5'b11100, 1'b0, 2'd0, 2'd0, 1'b1, 2'b10},
    {5'd0, 5'd0, 5'd3, 5'b11100, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd3, 5'd0, 5'd0, 5'b10110, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10},
    {5'd0, 5'd3, 5'd5, 5'b11100, 1'b0, 2'd0, 2'd1, 1'b0, 2'b10},
    {5'd5, 5'd5, 5'd5, 5'b11100, 1'b0, 2'd2, 2'd2, 1'b0, 2'b10},
    {5'd5, 5'd1, 5'd7, 5'b11100, 1'b0, 2'd2, 2'd0, 1'b0, 2'b10},
    {5'd2, 5'd0, 5'd9, 5'b10110, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd2, 5'd9, 5'd1, 5'b11100, 1'b1, 2'd0, 2'd0, 1'b0, 2'b00},
    {5'd2, 5'd9, 5'd1, 5'b11100, 1'b0, 2'd0, 2'd1, 1'b0, 2'b10},
    {5'd1, 5'd1, 5'd2, 5'b00100, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd0, 5'd0, 5'd4, 5'b10110, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd4, 5'd4, 5'd6, 5'b00100, 1'b0, 2'd0, 2'd0, 1'b0, 2'b10},
    {5'd2, 5'd1, 5'd6, 5'b11001, 1'b0, 2'd0, 2'd0, 1'b0, 2'b01},
    {5'd6, 5'd0, 5'd8, 5'b10100, 1'b0, 2'd1, 2'd0, 1'b0, 2'b10}
  };
  string row_req [NR] = '{"R3","R3","R4","R5","R3","R1","R4","R7","R9","R9",
                          "R7","R3","R7","R6","R6","R5","R1","R2","R8","R3",
                          "R8","R8","R8"};

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [27:0] r);
    {rs1, rs2, rd, u1, u2, wr, ld, st} = r[27:8];
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: outputs empty during and after reset
    chk("R10", "stall in reset", int'(stall), 0);
    chk("R10", "fwd_a in reset", int'(fa), 0);
    chk("R10", "ex_wr in reset", int'(exwr), 0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      drive(ROWS[i]);
      #2;
      chk(row_req[i], $sformatf("row %0d stall", i), int'(stall), int'(ROWS[i][7]));
      @(posedge clk);
      #1;
      chk(row_req[i], $sformatf("row %0d fwd_a", i), int'(fa), int'(ROWS[i][6:5]));
      chk(row_req[i], $sformatf("row %0d fwd_b", i), int'(fb), int'(ROWS[i][4:3]));
      chk(row_req[i], $sformatf("row %0d fwd_st", i), int'(fs), int'(ROWS[i][2]));
      chk(row_req[i], $sformatf("row %0d ex_wr", i), int'(exwr), int'(ROWS[i][1]));
      chk(row_req[i], $sformatf("row %0d ex_st", i), int'(exst), int'(ROWS[i][0]));
    end

    // R10: a load entering execute is forgotten by a reset
    @(negedge clk);
    {rs1, rs2, rd, u1, u2, wr, ld, st} = {5'd0, 5'd0, 5'd10, 5'b10110};
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    {rs1, rs2, rd, u1, u2, wr, ld, st} = {5'd10, 5'd10, 5'd11, 5'b11100};
    #2;
    chk("R10", "stall after reset", int'(stall), 0);
    chk("R10", "ex_wr after reset", int'(exwr), 0);
    @(posedge clk);
    #1;
    chk("R10", "fwd_a after reset", int'(fa), 0);
    chk("R10", "fwd_b after reset", int'(fb), 0);

    // R1: a load two cycles later is still stalled once, then bypassed (R4)
    @(negedge clk);
    {rs1, rs2, rd, u1, u2, wr, ld, st} = {5'd0, 5'd0, 5'd13, 5'b10110};
    @(negedge clk);
    {rs1, rs2, rd, u1, u2, wr, ld, st} = {5'd13, 5'd13, 5'd14, 5'b11100};
    #2;
    chk("R1", "back-to-back load use stall", int'(stall), 1);
    @(posedge clk);
    #1;
    chk("R2", "bubble ex_wr", int'(exwr), 0);
    #2;
    chk("R2", "stall released", int'(stall), 0);
    @(posedge clk);
    #1;
    chk("R4", "both operands from writeback", int'({fa, fb}), 4'b0101);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule